// File: doc/BRIEF.md
# AXI burst memory exerciser

This block is an AXI4 master that drives write and read tests into a memory controller. A command port hands it one job at a time: a direction (write or read), a size (a single beat or a long burst run), a 32-bit start address and a 64-bit seed word. A single job moves one 64-bit beat. A burst job moves 2048 bytes as sixteen 16-beat incrementing bursts, one after another. Each burst begins at the byte just past the end of the previous one.

On writes the block makes its own data. The seed goes out first, and every later beat carries the previous value plus one. On reads, each returned beat is copied to a capture port together with its position in the job, so that a buffer next to the block can keep it for the host. A bad response code on either channel sets a sticky error flag. A one-cycle done pulse marks the end of every job. A start address above the permitted range is refused without any bus traffic.

Top module: `axi_mem_exerciser`

## Requirements
- R1: While reset is held and after it is released, `cmd_ready` is 1, every AXI valid and ready output is 0, and `done` and `error` are 0.
- R2: The start address is aligned by clearing its bits [2:0]. The first address phase of a job carries this aligned value.
- R3: Every address phase uses size 3 (8 bytes) and burst type INCR (`2'b01`). Every data beat has all eight strobe bits set. A single job issues exactly one burst, with length field 0 and `wlast` set on its only beat.
- R4: A burst job issues 16 bursts with length field 15. Each burst's address is the previous burst's address plus 128.
- R5: Write data starts at the seed and rises by one on each beat, wrapping modulo 2^64, across all beats of the job. `wlast` is set on the 16th beat of each burst.
- R6: Only one burst is in flight at a time. No new address phase is offered until the current burst has completed: its write response has been taken, or its read beat with `rlast` has been taken.
- R7: In the same cycle as each read data handshake, `cap_valid` is 1, `cap_data` equals `rdata`, and `cap_idx` gives the beat's position in the job, counting from 0. `cap_valid` is 0 in every other cycle.
- R8: A `bresp` or `rresp` other than `2'b00` sets `error`. The job still runs to its end. `error` stays set until the next command is accepted, and a command that is accepted clears it.
- R9: `done` is high for exactly one cycle: the cycle that follows the completing handshake of the job's last burst. `cmd_ready` is 1 again in that same cycle.
- R10: A job whose aligned start is above 0x03FFFFF8 (single) or above 0x03FFF7F8 (burst) is refused. No AXI traffic occurs. `error` and `done` both rise in the cycle after acceptance.
- R11: `cmd_ready` is 0 from acceptance until the job ends. Commands offered during that time have no effect.
- R12: Once an address or write data valid is raised, it stays high with an unchanged payload until the slave accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_write | input | 1 | 1 = write job, 0 = read job |
| cmd_burst | input | 1 | 1 = sixteen 16-beat bursts, 0 = one beat |
| cmd_addr | input | 32 | Start byte address |
| cmd_seed | input | 64 | First write data word |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| awaddr | output | 32 | Write burst address |
| awlen | output | 8 | Write burst length minus one |
| awsize | output | 3 | Write beat size code |
| awburst | output | 2 | Write burst type |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| wdata | output | 64 | Write data |
| wstrb | output | 8 | Write byte strobes |
| wlast | output | 1 | Last beat of the burst |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response ready |
| bresp | input | 2 | Write response code |
| arvalid | output | 1 | Read address valid |
| arready | input | 1 | Read address ready |
| araddr | output | 32 | Read burst address |
| arlen | output | 8 | Read burst length minus one |
| arsize | output | 3 | Read beat size code |
| arburst | output | 2 | Read burst type |
| rvalid | input | 1 | Read data valid |
| rready | output | 1 | Read data ready |
| rdata | input | 64 | Read data |
| rresp | input | 2 | Read response code |
| rlast | input | 1 | Last read beat of the burst |
| cap_valid | output | 1 | Captured read beat valid |
| cap_data | output | 64 | Captured read beat |
| cap_idx | output | 8 | Beat position within the job |
| done | output | 1 | One-cycle end-of-job pulse |
| error | output | 1 | Sticky response or range error |

## Verification
Address, length and data fields are checked in the cycle of their handshake. The capture outputs are checked in the same cycle as the read handshake, because they are a combinational copy of it. `done`, `cmd_ready` and `error` depend on a registered state change, so they are expected exactly one cycle after the handshake that causes it. A refused command likewise shows its effect one cycle after acceptance.

The bench drives inputs and samples outputs at the falling edge. On every cycle it works out, from the handshakes that the coming rising edge will complete, the values due in the next cycle. It then compares those values against the outputs at the next falling edge. Slave stalls come from an LFSR, so every payload also has to survive a hold of several cycles.

// File: rtl/axi_exer_pkg.sv
package axi_exer_pkg;

    typedef enum logic [2:0] {
        XS_IDLE,
        XS_WADDR,
        XS_WDATA,
        XS_WRESP,
        XS_RADDR,
        XS_RDATA
    } xs_state_e;

    localparam logic [1:0] XBURST_INCR = 2'b01;
    localparam logic [1:0] XRESP_OKAY  = 2'b00;

endpackage

// File: rtl/axi_exer_range.sv
module axi_exer_range #(
    parameter int              ADDR_W     = 32,
    parameter int              ALIGN_BITS = 3,
    parameter logic [ADDR_W-1:0] SINGLE_MAX = 32'h03FF_FFF8,
    parameter logic [ADDR_W-1:0] BURST_MAX  = 32'h03FF_F7F8
) (
    input  logic [ADDR_W-1:0] raw_addr,
    input  logic              burst_mode,
    output logic [ADDR_W-1:0] aligned_addr,
    output logic              in_range
);
    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << ALIGN_BITS) - 1);

    always_comb begin
        aligned_addr = raw_addr & ~LOW_MASK;
        if (burst_mode) begin
            in_range = (aligned_addr <= BURST_MAX);
        end else begin
            in_range = (aligned_addr <= SINGLE_MAX);
        end
    end
endmodule

// File: rtl/axi_exer_pattern.sv
module axi_exer_pattern #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] seed,
    input  logic              step,
    output logic [DATA_W-1:0] value
);
    logic [DATA_W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (load) begin
            val_d = seed;
        end else if (step) begin
            val_d = val_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
        end else begin
            val_q <= val_d;
        end
    end

    assign value = val_q;
endmodule

// File: rtl/axi_exer_beatctr.sv
module axi_exer_beatctr #(
    parameter  int BEATS   = 16,
    parameter  int BURSTS  = 16,
    localparam int BEAT_W  = (BEATS > 1) ? $clog2(BEATS) : 1,
    localparam int BURST_W = (BURSTS > 1) ? $clog2(BURSTS) : 1,
    localparam int TOT_W   = ((BEATS * BURSTS) > 1) ? $clog2(BEATS * BURSTS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             burst_mode,
    input  logic             beat_step,
    input  logic             burst_step,
    output logic             last_beat,
    output logic             last_burst,
    output logic [TOT_W-1:0] total
);
    typedef struct packed {
        logic [BEAT_W-1:0]  beat;
        logic [BURST_W-1:0] burst;
        logic [TOT_W-1:0]   tot;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        last_beat  = burst_mode ? (ctr_q.beat == BEAT_W'(BEATS - 1)) : 1'b1;
        last_burst = burst_mode ? (ctr_q.burst == BURST_W'(BURSTS - 1)) : 1'b1;
    end

    always_comb begin
        ctr_d = ctr_q;
        if (clear) begin
            ctr_d = '0;
        end else begin
            if (beat_step) begin
                ctr_d.tot  = ctr_q.tot + 1'b1;
                ctr_d.beat = last_beat ? '0 : ctr_q.beat + 1'b1;
            end
            if (burst_step) begin
                ctr_d.burst = ctr_q.burst + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctr_q <= '0;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign total = ctr_q.tot;
endmodule

// File: rtl/axi_mem_exerciser.sv
module axi_mem_exerciser #(
    parameter  int              ADDR_W     = 32,
    parameter  int              DATA_W     = 64,
    parameter  int              BEATS      = 16,
    parameter  int              BURSTS     = 16,
    parameter  logic [ADDR_W-1:0] SINGLE_MAX = 32'h03FF_FFF8,
    parameter  logic [ADDR_W-1:0] BURST_MAX  = 32'h03FF_F7F8,
    localparam int              STRB_W     = DATA_W / 8,
    localparam int              TOT_W      = ((BEATS * BURSTS) > 1) ? $clog2(BEATS * BURSTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic              cmd_burst,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_seed,
    output logic              awvalid,
    input  logic              awready,
    output logic [ADDR_W-1:0] awaddr,
    output logic [7:0]        awlen,
    output logic [2:0]        awsize,
    output logic [1:0]        awburst,
    output logic              wvalid,
    input  logic              wready,
    output logic [DATA_W-1:0] wdata,
    output logic [STRB_W-1:0] wstrb,
    output logic              wlast,
    input  logic              bvalid,
    output logic              bready,
    input  logic [1:0]        bresp,
    output logic              arvalid,
    input  logic              arready,
    output logic [ADDR_W-1:0] araddr,
    output logic [7:0]        arlen,
    output logic [2:0]        arsize,
    output logic [1:0]        arburst,
    input  logic              rvalid,
    output logic              rready,
    input  logic [DATA_W-1:0] rdata,
    input  logic [1:0]        rresp,
    input  logic              rlast,
    output logic              cap_valid,
    output logic [DATA_W-1:0] cap_data,
    output logic [TOT_W-1:0]  cap_idx,
    output logic              done,
    output logic              error
);
    import axi_exer_pkg::*;

    localparam int              ALIGN_BITS  = $clog2(STRB_W);
    localparam logic [2:0]      SIZE_CODE   = 3'(ALIGN_BITS);
    localparam logic [7:0]      LEN_BURST   = 8'(BEATS - 1);
    localparam logic [ADDR_W-1:0] BURST_STEP = ADDR_W'(BEATS * STRB_W);

    typedef struct packed {
        xs_state_e         st;
        logic [ADDR_W-1:0] addr;
        logic              burst;
        logic              err;
        logic              done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [ADDR_W-1:0] start_addr;
    logic              start_ok;
    logic              pat_load, pat_step;
    logic [DATA_W-1:0] pat_value;
    logic              ctr_clear, beat_step, burst_step;
    logic              last_beat, last_burst;
    logic [TOT_W-1:0]  beat_total;

    axi_exer_range #(
        .ADDR_W    (ADDR_W),
        .ALIGN_BITS(ALIGN_BITS),
        .SINGLE_MAX(SINGLE_MAX),
        .BURST_MAX (BURST_MAX)
    ) u_range (
        .raw_addr    (cmd_addr),
        .burst_mode  (cmd_burst),
        .aligned_addr(start_addr),
        .in_range    (start_ok)
    );

    axi_exer_pattern #(
        .DATA_W(DATA_W)
    ) u_pattern (
        .clk  (clk),
        .rst_n(rst_n),
        .load (pat_load),
        .seed (cmd_seed),
        .step (pat_step),
        .value(pat_value)
    );

    axi_exer_beatctr #(
        .BEATS (BEATS),
        .BURSTS(BURSTS)
    ) u_beatctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (ctr_clear),
        .burst_mode(ctl_q.burst),
        .beat_step (beat_step),
        .burst_step(burst_step),
        .last_beat (last_beat),
        .last_burst(last_burst),
        .total     (beat_total)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        pat_load   = 1'b0;
        pat_step   = 1'b0;
        ctr_clear  = 1'b0;
        beat_step  = 1'b0;
        burst_step = 1'b0;

        unique case (ctl_q.st)
            XS_IDLE: begin
                if (cmd_valid) begin
                    if (!start_ok) begin
                        ctl_d.err  = 1'b1;
                        ctl_d.done = 1'b1;
                    end else begin
                        ctl_d.err   = 1'b0;
                        ctl_d.addr  = start_addr;
                        ctl_d.burst = cmd_burst;
                        ctl_d.st    = cmd_write ? XS_WADDR : XS_RADDR;
                        pat_load    = 1'b1;
                        ctr_clear   = 1'b1;
                    end
                end
            end
            XS_WADDR: begin
                if (awready) begin
                    ctl_d.st = XS_WDATA;
                end
            end
            XS_WDATA: begin
                if (wready) begin
                    pat_step  = 1'b1;
                    beat_step = 1'b1;
                    if (last_beat) begin
                        ctl_d.st = XS_WRESP;
                    end
                end
            end
            XS_WRESP: begin
                if (bvalid) begin
                    if (bresp != XRESP_OKAY) begin
                        ctl_d.err = 1'b1;
                    end
                    if (last_burst) begin
                        ctl_d.st   = XS_IDLE;
                        ctl_d.done = 1'b1;
                    end else begin
                        burst_step = 1'b1;
                        ctl_d.addr = ctl_q.addr + BURST_STEP;
                        ctl_d.st   = XS_WADDR;
                    end
                end
            end
            XS_RADDR: begin
                if (arready) begin
                    ctl_d.st = XS_RDATA;
                end
            end
            XS_RDATA: begin
                if (rvalid) begin
                    beat_step = 1'b1;
                    if (rresp != XRESP_OKAY) begin
                        ctl_d.err = 1'b1;
                    end
                    if (rlast) begin
                        if (last_burst) begin
                            ctl_d.st   = XS_IDLE;
                            ctl_d.done = 1'b1;
                        end else begin
                            burst_step = 1'b1;
                            ctl_d.addr = ctl_q.addr + BURST_STEP;
                            ctl_d.st   = XS_RADDR;
                        end
                    end
                end
            end
            default: ctl_d.st = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: XS_IDLE, addr: '0, burst: 1'b0, err: 1'b0, done: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cmd_ready = (ctl_q.st == XS_IDLE);

    assign awvalid = (ctl_q.st == XS_WADDR);
    assign awaddr  = ctl_q.addr;
    assign awlen   = ctl_q.burst ? LEN_BURST : 8'd0;
    assign awsize  = SIZE_CODE;
    assign awburst = XBURST_INCR;

    assign wvalid = (ctl_q.st == XS_WDATA);
    assign wdata  = pat_value;
    assign wstrb  = '1;
    assign wlast  = last_beat;

    assign bready = (ctl_q.st == XS_WRESP);

    assign arvalid = (ctl_q.st == XS_RADDR);
    assign araddr  = ctl_q.addr;
    assign arlen   = ctl_q.burst ? LEN_BURST : 8'd0;
    assign arsize  = SIZE_CODE;
    assign arburst = XBURST_INCR;

    assign rready = (ctl_q.st == XS_RDATA);

    assign cap_valid = rvalid && (ctl_q.st == XS_RDATA);
    assign cap_data  = rdata;
    assign cap_idx   = beat_total;

    assign done  = ctl_q.done;
    assign error = ctl_q.err;
endmodule

// File: rtl/axi_exer_checks.sv
module axi_exer_checks #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              awvalid,
    input logic              awready,
    input logic [ADDR_W-1:0] awaddr,
    input logic [7:0]        awlen,
    input logic              wvalid,
    input logic              wready,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W/8-1:0] wstrb,
    input logic              wlast,
    input logic              bready,
    input logic              arvalid,
    input logic              arready,
    input logic [ADDR_W-1:0] araddr,
    input logic              rvalid,
    input logic              rready,
    input logic              cap_valid,
    input logic              done,
    input logic              error
);
    p_aw_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        awvalid && !awready |=> awvalid && $stable(awaddr) && $stable(awlen));

    p_w_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wvalid && !wready |=> wvalid && $stable(wdata) && $stable(wlast));

    p_ar_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        arvalid && !arready |=> arvalid && $stable(araddr));

    p_aw_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
        awvalid |-> (awaddr[2:0] == 3'b000));

    p_ar_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
        arvalid |-> (araddr[2:0] == 3'b000));

    p_strb_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wvalid |-> (&wstrb));

    p_one_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({awvalid, wvalid, bready, arvalid, rready}));

    p_cap_hs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |-> rvalid && rready);

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        error && !(cmd_valid && cmd_ready) |=> error);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cmd_ready);

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !awvalid && !wvalid && !arvalid && !bready && !rready);
endmodule

bind axi_mem_exerciser axi_exer_checks #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready),
    .awvalid  (awvalid),
    .awready  (awready),
    .awaddr   (awaddr),
    .awlen    (awlen),
    .wvalid   (wvalid),
    .wready   (wready),
    .wdata    (wdata),
    .wstrb    (wstrb),
    .wlast    (wlast),
    .bready   (bready),
    .arvalid  (arvalid),
    .arready  (arready),
    .araddr   (araddr),
    .rvalid   (rvalid),
    .rready   (rready),
    .cap_valid(cap_valid),
    .done     (done),
    .error    (error)
);

// File: tb/axi_mem_exerciser_tb.sv
module axi_mem_exerciser_tb;
    localparam logic [31:0] SMAX = 32'h03FF_FFF8;
    localparam logic [31:0] BMAX = 32'h03FF_F7F8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_write = 1'b0, cmd_burst = 1'b0;
    logic [31:0] cmd_addr = '0;
    logic [63:0] cmd_seed = '0;
    logic        cmd_ready;
    logic        awvalid, awready = 1'b0;
    logic [31:0] awaddr;
    logic [7:0]  awlen;
    logic [2:0]  awsize;
    logic [1:0]  awburst;
    logic        wvalid, wready = 1'b0, wlast;
    logic [63:0] wdata;
    logic [7:0]  wstrb;
    logic        bvalid = 1'b0, bready;
    logic [1:0]  bresp = 2'b00;
    logic        arvalid, arready = 1'b0;
    logic [31:0] araddr;
    logic [7:0]  arlen;
    logic [2:0]  arsize;
    logic [1:0]  arburst;
    logic        rvalid = 1'b0, rready, rlast = 1'b0;
    logic [63:0] rdata = '0;
    logic [1:0]  rresp = 2'b00;
    logic        cap_valid;
    logic [63:0] cap_data;
    logic [7:0]  cap_idx;
    logic        done, error;

    always #10 clk = ~clk;

    axi_mem_exerciser u_dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
        .cmd_burst(cmd_burst), .cmd_addr(cmd_addr), .cmd_seed(cmd_seed),
        .awvalid(awvalid), .awready(awready), .awaddr(awaddr), .awlen(awlen),
        .awsize(awsize), .awburst(awburst),
        .wvalid(wvalid), .wready(wready), .wdata(wdata), .wstrb(wstrb), .wlast(wlast),
        .bvalid(bvalid), .bready(bready), .bresp(bresp),
        .arvalid(arvalid), .arready(arready), .araddr(araddr), .arlen(arlen),
        .arsize(arsize), .arburst(arburst),
        .rvalid(rvalid), .rready(rready), .rdata(rdata), .rresp(rresp), .rlast(rlast),
        .cap_valid(cap_valid), .cap_data(cap_data), .cap_idx(cap_idx),
        .done(done), .error(error)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;

    logic [63:0] mem [int];
    logic [15:0] lf = 16'hACE1;
    bit  stall = 0;
    int  inj_b_burst = -1, inj_r_beat = -1;

    bit  s_b_pend = 0, b_taken = 0, r_taken = 0, s_r_act = 0;
    int  s_b_wait = 0, s_widx = 0, s_wbeat = 0;
    logic [1:0] s_b_resp = 2'b00;
    int  s_r_idx = 0, s_r_beat = 0, s_r_len = 0, s_r_tot = 0;

    bit  e_idle = 1, e_done = 0, e_err = 0;
    bit  nxt_idle, nxt_done, nxt_err;
    bit  m_out = 0, m_burst = 0, accepted = 0;
    int  m_nb = 0, m_len = 0, m_bcnt = 0, m_beat = 0, m_total = 0;
    logic [31:0] m_addr = '0;
    logic [63:0] m_data = '0;
    bit  rd_pat_chk = 0;
    logic [63:0] rd_seed = '0;
    bit  prev_aw = 0, prev_w = 0;
    logic [31:0] prev_awaddr = '0;
    logic [63:0] prev_wdata = '0;

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    function automatic logic [63:0] rd_mem(int i);
        if (mem.exists(i)) return mem[i];
        return {32'(i), ~32'(i)};
    endfunction

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    task automatic complete_burst();
        m_out = 0;
        m_bcnt++;
        m_addr = m_addr + 32'(8 * (m_len + 1));
        if (m_bcnt == m_nb) begin
            nxt_done = 1;
            nxt_idle = 1;
        end
    endtask

    task automatic step();
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            finish_run();
        end
        // per-cycle comparisons against the model
        chk("R9", "done", 64'(done), 64'(e_done));
        chk("R11", "cmd_ready", 64'(cmd_ready), 64'(e_idle));
        chk("R8", "error", 64'(error), 64'(e_err));
        if (m_out) chk("R6", "address valid while burst outstanding", 64'(awvalid | arvalid), 64'd0);
        if (prev_aw) begin
            chk("R12", "awvalid held", 64'(awvalid), 64'd1);
            chk("R12", "awaddr held", 64'(awaddr), 64'(prev_awaddr));
        end
        if (prev_w) begin
            chk("R12", "wvalid held", 64'(wvalid), 64'd1);
            chk("R12", "wdata held", wdata, prev_wdata);
        end
        // slave drive
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        awready = stall ? lf[0] : 1'b1;
        wready  = stall ? lf[1] : 1'b1;
        arready = stall ? lf[2] : 1'b1;
        if (b_taken) begin bvalid = 0; b_taken = 0; end
        if (s_b_pend && !bvalid) begin
            if (s_b_wait == 0) begin bvalid = 1; bresp = s_b_resp; end
            else s_b_wait--;
        end
        if (r_taken) begin rvalid = 0; r_taken = 0; end
        if (s_r_act && !rvalid && (!stall || lf[3])) begin
            rvalid = 1;
            rdata  = rd_mem(s_r_idx + s_r_beat);
            rlast  = (s_r_beat == s_r_len);
            rresp  = (s_r_tot == inj_r_beat) ? 2'b10 : 2'b00;
        end
        #1;
        // handshakes that the coming edge completes
        accepted = 0;
        nxt_done = 0;
        nxt_idle = e_idle;
        nxt_err  = e_err;
        chk("R7", "cap_valid", 64'(cap_valid), 64'(rvalid & rready));
        if (cmd_valid && e_idle) begin
            logic [31:0] a;
            bit ok;
            accepted = 1;
            a  = cmd_addr & ~32'h7;
            ok = cmd_burst ? (a <= BMAX) : (a <= SMAX);
            if (!ok) begin
                nxt_err  = 1;
                nxt_done = 1;
            end else begin
                nxt_err = 0;
                nxt_idle = 0;
                m_burst = cmd_burst;
                m_nb    = cmd_burst ? 16 : 1;
                m_len   = cmd_burst ? 15 : 0;
                m_addr  = a;
                m_data  = cmd_seed;
                m_bcnt  = 0;
                m_beat  = 0;
                m_total = 0;
                m_out   = 0;
                s_r_tot = 0;
            end
        end
        if (awvalid && awready) begin
            chk((m_bcnt == 0) ? "R2" : "R4", "awaddr", 64'(awaddr), 64'(m_addr));
            chk(m_burst ? "R4" : "R3", "awlen", 64'(awlen), 64'(m_len));
            chk("R3", "awsize", 64'(awsize), 64'd3);
            chk("R3", "awburst", 64'(awburst), 64'd1);
            m_out   = 1;
            s_widx  = int'(awaddr >> 3);
            s_wbeat = 0;
        end
        if (wvalid && wready) begin
            chk("R5", "wdata", wdata, m_data);
            chk("R5", "wlast", 64'(wlast), 64'(m_beat == m_len));
            chk("R3", "wstrb", 64'(wstrb), 64'hFF);
            mem[s_widx + s_wbeat] = wdata;
            s_wbeat++;
            m_data = m_data + 64'd1;
            if (m_beat == m_len) begin
                m_beat   = 0;
                s_b_pend = 1;
                s_b_wait = stall ? int'(lf[5:4]) : 0;
                s_b_resp = (m_bcnt == inj_b_burst) ? 2'b10 : 2'b00;
            end else begin
                m_beat++;
            end
        end
        if (bvalid && bready) begin
            b_taken  = 1;
            s_b_pend = 0;
            if (bresp != 2'b00) nxt_err = 1;
            complete_burst();
        end
        if (arvalid && arready) begin
            chk((m_bcnt == 0) ? "R2" : "R4", "araddr", 64'(araddr), 64'(m_addr));
            chk(m_burst ? "R4" : "R3", "arlen", 64'(arlen), 64'(m_len));
            chk("R3", "arsize", 64'(arsize), 64'd3);
            chk("R3", "arburst", 64'(arburst), 64'd1);
            m_out    = 1;
            s_r_act  = 1;
            s_r_idx  = int'(araddr >> 3);
            s_r_beat = 0;
            s_r_len  = int'(arlen);
        end
        if (rvalid && rready) begin
            chk("R7", "cap_idx", 64'(cap_idx), 64'(m_total));
            chk("R7", "cap_data", cap_data, rdata);
            if (rd_pat_chk) chk("R5", "read back pattern", cap_data, rd_seed + 64'(m_total));
            if (rresp != 2'b00) nxt_err = 1;
            m_total++;
            s_r_tot++;
            r_taken = 1;
            if (rlast) begin
                s_r_act = 0;
                complete_burst();
            end else begin
                s_r_beat++;
            end
        end
        prev_aw     = awvalid && !awready;
        prev_awaddr = awaddr;
        prev_w      = wvalid && !wready;
        prev_wdata  = wdata;
        e_idle = nxt_idle;
        e_done = nxt_done;
        e_err  = nxt_err;
        @(negedge clk);
    endtask

    task automatic run_cmd(bit wr, bit bu, logic [31:0] addr, logic [63:0] seed);
        cmd_write = wr;
        cmd_burst = bu;
        cmd_addr  = addr;
        cmd_seed  = seed;
        cmd_valid = 1;
        do step(); while (!accepted);
        cmd_valid = 0;
        do step(); while (!e_idle);
        step();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs under reset
        chk("R1", "cmd_ready in reset", 64'(cmd_ready), 64'd1);
        chk("R1", "valids in reset", 64'({awvalid, wvalid, arvalid, bready, rready}), 64'd0);
        chk("R1", "done/error in reset", 64'({done, error}), 64'd0);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "idle after reset", 64'({cmd_ready, awvalid, wvalid, arvalid, done, error}), 64'h20);
        step();

        // R2 R3: single write at an unaligned address, then read it back
        run_cmd(1, 0, 32'h0000_0105, 64'h0123_4567_89AB_CDEF);
        chk("R3", "single write stored", rd_mem(32'h100 >> 3), 64'h0123_4567_89AB_CDEF);
        run_cmd(0, 0, 32'h0000_0103, 64'h0);
        chk("R7", "single read last beat count", 64'(m_total), 64'd1);

        // R4 R5: burst write with seed near wrap, stalled slave
        stall = 1;
        run_cmd(1, 1, 32'h0000_2000, 64'hFFFF_FFFF_FFFF_FFF8);
        chk("R5", "last burst word", rd_mem((32'h2000 >> 3) + 255), 64'hFFFF_FFFF_FFFF_FFF8 + 64'd255);
        chk("R4", "bursts issued", 64'(m_bcnt), 64'd16);
        rd_pat_chk = 1;
        rd_seed    = 64'hFFFF_FFFF_FFFF_FFF8;
        run_cmd(0, 1, 32'h0000_2000, 64'h0);
        rd_pat_chk = 0;
        chk("R7", "beats captured", 64'(m_total), 64'd256);

        // R8: write error on burst 5, then cleared by the next command
        inj_b_burst = 5;
        run_cmd(1, 1, 32'h0001_0000, 64'h10);
        inj_b_burst = -1;
        chk("R8", "error after bad bresp", 64'(error), 64'd1);
        chk("R8", "job ran to end", 64'(m_bcnt), 64'd16);
        run_cmd(0, 0, 32'h0001_0000, 64'h0);
        chk("R8", "error cleared by new command", 64'(error), 64'd0);
        inj_r_beat = 37;
        run_cmd(0, 1, 32'h0001_0000, 64'h0);
        inj_r_beat = -1;
        chk("R8", "error after bad rresp", 64'(error), 64'd1);

        // R10: range edges
        stall = 0;
        run_cmd(1, 0, 32'h03FF_FFFF, 64'hAA);
        chk("R10", "top single accepted", 64'(error), 64'd0);
        run_cmd(1, 0, 32'h0400_0000, 64'hBB);
        chk("R10", "single above range refused", 64'(error), 64'd1);
        chk("R10", "refused job no burst", 64'(m_out), 64'd0);
        run_cmd(0, 1, 32'h03FF_F7F8, 64'h0);
        chk("R10", "top burst accepted", 64'(error), 64'd0);
        run_cmd(1, 1, 32'h03FF_F800, 64'h0);
        chk("R10", "burst above range refused", 64'(error), 64'd1);

        // R11: command offered while busy is ignored
        stall = 1;
        cmd_write = 0; cmd_burst = 1; cmd_addr = 32'h0000_4000; cmd_valid = 1;
        do step(); while (!accepted);
        cmd_valid = 0;
        repeat (5) step();
        cmd_write = 1; cmd_burst = 0; cmd_addr = 32'hFFFF_FFF0; cmd_valid = 1;
        repeat (6) step();
        cmd_valid = 0;
        chk("R11", "busy command did not set error", 64'(error), 64'd0);
        do step(); while (!e_idle);
        step();
        chk("R11", "busy command had no effect", 64'(error), 64'd0);
        chk("R11", "busy job completed", 64'(m_total), 64'd256);
        repeat (3) step();

        finish_run();
    end
endmodule